// File: doc/BRIEF.md
# Compensated Time-of-Day Counter

This block keeps a 64-bit nanosecond time value that advances by a programmable step on every reference clock tick. A frequency trim can be switched on. Once every N ticks, where N is programmable, the tick adds a separate compensation step in place of the normal step. This slows or speeds the clock by a fixed amount per N ticks.

Software reaches the block through a single-cycle register port. It sees the time as two 32-bit words. A read of the low word freezes a copy of the high word, so the high word read that follows belongs to the same instant. A write to the high word is held aside. The next write to the low word then loads all 64 bits in one step. A sticky flag records a wrap past the top of the 64-bit range.

Top module: `tod_counter`

## Requirements
- R1: After reset, every register reads 0. The registers are at word addresses 0 config, 1 compensation count, 2 slow period, 3 time low, 4 time high and 5 status.
- R2: Config (address 0) holds the enable in bit 0, the 4-bit default step in bits 7:4 and the 12-bit compensation step in bits 19:8. All other bits read as 0.
- R3: While enabled, each tick adds the default step to the 64-bit time, and the carry passes from the low word into the high word.
- R4: While the enable bit is 0, the time holds its value.
- R5: With a nonzero slow period P, every P-th enabled tick adds the compensation step instead of the default step. A write to the slow period restarts the tick countdown from P.
- R6: A slow period of 0 turns off the substitution, so the compensation step is never used.
- R7: A read of the time low word captures the high word in the same cycle. A later read of the time high word returns that captured value, even if the live time has moved on.
- R8: A write to the time high word does not change the time. A write to the time low word loads the full time from that data and the last high word written.
- R9: A write to the time low word in a tick where counting is enabled takes priority over the increment.
- R10: The overflow flag (status bit 0) sets when an increment carries out of bit 63. It then stays set.
- R11: Writing 1 to status bit 0 clears the overflow flag. Writing 0 leaves it unchanged.
- R12: The compensation count register stores values up to 0xFFFFFF. A larger write stores 0xFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one tick per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid in the cycle of rdEn (0 when idle) |

## Verification
The bench builds the block with its default parameters: a 64-bit time, 32-bit register words, a 4-bit default step, a 12-bit compensation step and a 24-bit compensation count limit. These widths let the bench load values just under a 32-bit or 64-bit boundary. Within one or two ticks it can then reach the word carry, the full wrap with its overflow flag, and a high-word change between the low and high reads. Small slow periods (1, 2, 3) make the substitution pattern visible within a handful of ticks.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] REG_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] REG_CCNT = 3'd1;
  localparam logic [ADDR_W-1:0] REG_SLOW = 3'd2;
  localparam logic [ADDR_W-1:0] REG_TLO  = 3'd3;
  localparam logic [ADDR_W-1:0] REG_THI  = 3'd4;
  localparam logic [ADDR_W-1:0] REG_STAT = 3'd5;

  // strobes from control to datapath, one set per tick
  typedef struct packed {
    logic advance;   // counting enabled this tick
    logic useComp;   // this tick takes the compensation step
    logic loadHi;    // stash pending high word
    logic loadTime;  // load full time from low write + pending high
    logic latchHi;   // low word read: freeze high word
    logic clrOvf;    // software clears overflow
  } todStrobe_t;
endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DEF_INC_W  = 4,
  parameter int unsigned COMP_INC_W = 12,
  parameter int unsigned CCNT_W     = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  output todStrobe_t            strobe,
  output logic [DEF_INC_W-1:0]  defInc,
  output logic [COMP_INC_W-1:0] compInc,
  output logic [DATA_W-1:0]     cfgWord,
  output logic [CCNT_W-1:0]     compCount,
  output logic [DATA_W-1:0]     slowPeriod
);
  localparam int unsigned DEF_LSB  = 4;
  localparam int unsigned COMP_LSB = DEF_LSB + DEF_INC_W;
  localparam int unsigned COMP_MSB = COMP_LSB + COMP_INC_W - 1;
  localparam logic [DATA_W-1:0] CCNT_LIMIT = DATA_W'((64'd1 << CCNT_W) - 64'd1);

  logic              cfgEn;
  logic [DATA_W-1:0] tickLeft;
  logic              slowOn;
  logic              expire;

  wire wrCfg  = wrEn && (addr == REG_CFG);
  wire wrCcnt = wrEn && (addr == REG_CCNT);
  wire wrSlow = wrEn && (addr == REG_SLOW);

  assign slowOn = (slowPeriod != '0);
  assign expire = slowOn && (tickLeft <= DATA_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn     <= 1'b0;
      defInc    <= '0;
      compInc   <= '0;
      compCount <= '0;
    end else begin
      if (wrCfg) begin
        cfgEn   <= wrData[0];
        defInc  <= wrData[COMP_LSB-1:DEF_LSB];
        compInc <= wrData[COMP_MSB:COMP_LSB];
      end
      if (wrCcnt) begin
        if (wrData > CCNT_LIMIT) compCount <= '1;
        else                     compCount <= wrData[CCNT_W-1:0];
      end
    end
  end

  // slow compensation countdown, reloads from the period on expiry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slowPeriod <= '0;
      tickLeft   <= '0;
    end else if (wrSlow) begin
      slowPeriod <= wrData;
      tickLeft   <= wrData;
    end else if (cfgEn && slowOn) begin
      tickLeft <= expire ? slowPeriod : tickLeft - DATA_W'(1);
    end
  end

  always_comb begin
    strobe.advance  = cfgEn;
    strobe.useComp  = cfgEn && expire;
    strobe.loadHi   = wrEn && (addr == REG_THI);
    strobe.loadTime = wrEn && (addr == REG_TLO);
    strobe.latchHi  = rdEn && (addr == REG_TLO);
    strobe.clrOvf   = wrEn && (addr == REG_STAT) && wrData[0];
  end

  always_comb begin
    cfgWord                    = '0;
    cfgWord[0]                 = cfgEn;
    cfgWord[COMP_LSB-1:DEF_LSB] = defInc;
    cfgWord[COMP_MSB:COMP_LSB]  = compInc;
  end
endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter int unsigned CNT_W      = 64,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DEF_INC_W  = 4,
  parameter int unsigned COMP_INC_W = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  todStrobe_t              strobe,
  input  logic [DEF_INC_W-1:0]    defInc,
  input  logic [COMP_INC_W-1:0]   compInc,
  input  logic [DATA_W-1:0]       wrData,
  output logic [CNT_W-1:0]        timeNow,
  output logic [CNT_W-DATA_W-1:0] hiShadow,
  output logic                    ovfFlag
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  logic [HI_W-1:0]  pendingHi;
  logic [CNT_W-1:0] stepVal;
  logic [CNT_W:0]   sum;

  always_comb begin
    stepVal = strobe.useComp ? CNT_W'(compInc) : CNT_W'(defInc);
    sum     = {1'b0, timeNow} + {1'b0, stepVal};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeNow   <= '0;
      pendingHi <= '0;
      hiShadow  <= '0;
      ovfFlag   <= 1'b0;
    end else begin
      if (strobe.loadHi) pendingHi <= wrData[HI_W-1:0];
      if (strobe.loadTime)     timeNow <= {pendingHi, wrData};
      else if (strobe.advance) timeNow <= sum[CNT_W-1:0];
      if (strobe.latchHi) hiShadow <= timeNow[CNT_W-1:DATA_W];
      if (strobe.advance && !strobe.loadTime && sum[CNT_W]) ovfFlag <= 1'b1;
      else if (strobe.clrOvf)                               ovfFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int unsigned CNT_W      = 64,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DEF_INC_W  = 4,
  parameter int unsigned COMP_INC_W = 12,
  parameter int unsigned CCNT_W     = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  todStrobe_t            strobe;
  logic [DEF_INC_W-1:0]  defInc;
  logic [COMP_INC_W-1:0] compInc;
  logic [DATA_W-1:0]     cfgWord;
  logic [CCNT_W-1:0]     compCount;
  logic [DATA_W-1:0]     slowPeriod;
  logic [CNT_W-1:0]      timeNow;
  logic [HI_W-1:0]       hiShadow;
  logic                  ovfFlag;
  logic                  cntEnable;

  assign cntEnable = strobe.advance;

  tod_ctrl #(
    .DATA_W(DATA_W), .DEF_INC_W(DEF_INC_W), .COMP_INC_W(COMP_INC_W), .CCNT_W(CCNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .strobe(strobe), .defInc(defInc), .compInc(compInc), .cfgWord(cfgWord),
    .compCount(compCount), .slowPeriod(slowPeriod)
  );

  tod_datapath #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .DEF_INC_W(DEF_INC_W), .COMP_INC_W(COMP_INC_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .defInc(defInc), .compInc(compInc),
    .wrData(wrData), .timeNow(timeNow), .hiShadow(hiShadow), .ovfFlag(ovfFlag)
  );

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (addr)
        REG_CFG:  rdData = cfgWord;
        REG_CCNT: rdData = DATA_W'(compCount);
        REG_SLOW: rdData = slowPeriod;
        REG_TLO:  rdData = timeNow[DATA_W-1:0];
        REG_THI:  rdData = DATA_W'(hiShadow);
        REG_STAT: rdData = DATA_W'(ovfFlag);
        default:  rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/tod_checker.sv
module tod_checker
  import tod_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [CNT_W-1:0]  timeNow,
  input logic              cntEnable,
  input logic              ovfFlag
);
  localparam logic [DATA_W-1:0] CFG_RSVD  = ~DATA_W'(32'h000F_FFF1);
  localparam logic [DATA_W-1:0] CCNT_RSVD = ~DATA_W'(32'h00FF_FFFF);

  wire loWr  = wrEn && (addr == REG_TLO);
  wire clrWr = wrEn && (addr == REG_STAT) && wrData[0];

  AST_CFG_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == REG_CFG) |-> ((rdData & CFG_RSVD) == '0)); // R2

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEnable && !loWr) |=> $stable(timeNow)); // R4

  AST_LOAD_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    loWr |=> (timeNow[DATA_W-1:0] == $past(wrData))); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !clrWr) |=> ovfFlag); // R10

  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && !cntEnable) |=> !ovfFlag); // R11

  AST_CCNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == REG_CCNT) |-> ((rdData & CCNT_RSVD) == '0)); // R12
endmodule

bind tod_counter tod_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .timeNow(timeNow), .cntEnable(cntEnable), .ovfFlag(ovfFlag)
);

// File: tb/tod_counter_tb.sv
module tod_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CFG = 3'd0, A_CCNT = 3'd1, A_SLOW = 3'd2,
                         A_TLO = 3'd3, A_THI = 3'd4, A_STAT = 3'd5;

  typedef struct packed {
    logic [31:0] startHi;
    logic [31:0] startLo;
    logic [3:0]  defStep;
    logic [11:0] compStep;
    logic [31:0] period;
    logic [15:0] ticks;
    logic [31:0] expHi;
    logic [31:0] expLo;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0,        32'h0,         4'd4,  12'd0, 32'd0, 16'd10, 32'h0,        32'd40},       // R3
    '{32'h0,        32'hFFFF_FFF0, 4'd15, 12'd0, 32'd0, 16'd2,  32'h1,        32'h0000_000E},// R3 carry
    '{32'h0,        32'd100,       4'd4,  12'd5, 32'd3, 16'd7,  32'h0,        32'd130},      // R5
    '{32'h0,        32'd0,         4'd8,  12'd7, 32'd1, 16'd5,  32'h0,        32'd35},       // R5
    '{32'h1234_5678,32'd5,         4'd1,  12'd0, 32'd2, 16'd6,  32'h1234_5678,32'd8},        // R5
    '{32'h0,        32'd20,        4'd4,  12'd9, 32'd0, 16'd6,  32'h0,        32'd44}        // R6
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_counter dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  // exactly n enabled ticks, then disabled
  task automatic runTicks(input logic [31:0] cfg, input int n);
    regWrite(A_CFG, cfg | 32'h1);
    repeat (n - 1) @(negedge clk);
    wrEn = 1'b1; addr = A_CFG; wrData = cfg & ~32'h1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic finish;
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [31:0] r, cfg;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    for (int a = 0; a < 6; a++) begin
      regRead(3'(a), r);
      check("R1 reset", r, 32'h0);
    end

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      cfg = {12'h0, VECS[i].compStep, VECS[i].defStep, 4'h0};
      regWrite(A_CFG, cfg);
      regWrite(A_SLOW, VECS[i].period);
      regWrite(A_THI, VECS[i].startHi);
      regWrite(A_TLO, VECS[i].startLo);
      runTicks(cfg, int'(VECS[i].ticks));
      regRead(A_TLO, r);
      check($sformatf("R3/R5/R6 vec%0d low", i), r, VECS[i].expLo);
      regRead(A_THI, r);
      check($sformatf("R3/R5/R6 vec%0d high", i), r, VECS[i].expHi);
    end
    regWrite(A_SLOW, 32'd0);

    // R2 config layout
    regWrite(A_CFG, 32'hFFFF_FFF0);
    regRead(A_CFG, r);
    check("R2 cfg fields", r, 32'h000F_FFF0);

    // R4 hold while disabled
    regWrite(A_CFG, 32'h40);
    regWrite(A_THI, 32'h0);
    regWrite(A_TLO, 32'd321);
    repeat (5) @(negedge clk);
    regRead(A_TLO, r);
    check("R4 hold", r, 32'd321);

    // R8 pending high word
    regWrite(A_TLO, 32'd50);
    regWrite(A_THI, 32'd7);
    regRead(A_TLO, r);
    check("R8 low after high write", r, 32'd50);
    regRead(A_THI, r);
    check("R8 high not loaded yet", r, 32'd0);
    regWrite(A_TLO, 32'd60);
    regRead(A_TLO, r);
    check("R8 full load low", r, 32'd60);
    regRead(A_THI, r);
    check("R8 full load high", r, 32'd7);

    // R7 coherent high latch while running
    regWrite(A_THI, 32'h0);
    regWrite(A_TLO, 32'hFFFF_FFFB);
    regWrite(A_CFG, 32'h21);
    regRead(A_TLO, r);
    check("R7 low while running", r, 32'hFFFF_FFFD);
    repeat (4) @(negedge clk);
    regRead(A_THI, r);
    check("R7 high frozen at low read", r, 32'h0);
    regWrite(A_CFG, 32'h20);
    regRead(A_TLO, r);
    regRead(A_THI, r);
    check("R7 high relatched", r, 32'h1);

    // R9 low write beats increment
    regWrite(A_THI, 32'h0);
    regWrite(A_CFG, 32'h41);
    regWrite(A_TLO, 32'd1000);
    regWrite(A_CFG, 32'h40);
    regRead(A_TLO, r);
    check("R9 load priority", r, 32'd1008);

    // R10/R11 overflow
    regWrite(A_THI, 32'hFFFF_FFFF);
    regWrite(A_TLO, 32'hFFFF_FFFE);
    runTicks(32'h30, 1);
    regRead(A_TLO, r);
    check("R10 wrap low", r, 32'h1);
    regRead(A_THI, r);
    check("R10 wrap high", r, 32'h0);
    regRead(A_STAT, r);
    check("R10 overflow set", r, 32'h1);
    regWrite(A_STAT, 32'h0);
    regRead(A_STAT, r);
    check("R11 write 0 keeps flag", r, 32'h1);
    regWrite(A_STAT, 32'h1);
    regRead(A_STAT, r);
    check("R11 write 1 clears", r, 32'h0);

    // R12 compensation count saturation
    regWrite(A_CCNT, 32'h0100_0000);
    regRead(A_CCNT, r);
    check("R12 saturate", r, 32'h00FF_FFFF);
    regWrite(A_CCNT, 32'h0012_3456);
    regRead(A_CCNT, r);
    check("R12 in range", r, 32'h0012_3456);

    finish();
  end
endmodule